// File: doc/BRIEF.md
# Control-Flow and Interrupt Sequencer

This block owns the program counter and the stack pointer of a small 16-bit processor core and decides, once per retired instruction, where execution goes next. For a control-flow instruction it picks the jump target (a register operand or the value on top of the stack), applies it absolutely or relative to the current address, and raises stack push and pop requests for call and return style sequences. It also holds the interrupt-enable flag, which a control-flow instruction can set or clear, and it services a keyboard interrupt line between instructions.

Each cycle in which `step_valid` is high, the core presents one instruction: a flag saying whether it is a control-flow instruction, the outcome of its predicate, its six modifier bits, the register operand and the current top-of-stack word. On the next rising clock edge the block updates its registered outputs: the new program counter, the new stack pointer, the enable flag and a one-cycle stack write or pop request for the stack memory outside the block. Instruction fetch and the stack storage itself live elsewhere.

Top module: `cflow_irq_unit`

## Requirements
- R1: After synchronous reset `pc_o` is 0, `sp_o` is SP_RESET (default 0), `ien_o` is 0 and `push_o`, `pop_o` and `irq_taken_o` are 0.
- R2: A step that is not a control-flow instruction, or whose predicate fails, sets `pc_o` to `pc_o + 2` modulo 2^16, leaves `sp_o` and `ien_o` unchanged and raises no stack request.
- R3: In an executed control-flow step, modifier bit 5 (relative) = 0 loads the target into `pc_o`; bit 5 = 1 sets `pc_o` to `pc_o + target` modulo 2^16. The target is `reg_operand` unless a pop is selected.
- R4: Modifier bit 3 (pop) = 1 takes `stack_rdata` as the target, pulses `pop_o` and increments `sp_o` by one.
- R5: Modifier bit 4 (push) = 1 pulses `push_o` with `push_data_o` equal to the address of the instruction. With push alone, `sp_o` decreases by one and `push_addr_o` equals the new `sp_o`; with push and pop together, `sp_o` is unchanged and `push_addr_o` equals it.
- R6: Modifier bits [1:0] = 2'b10 clear `ien_o`, 2'b11 set it, 2'b00 and 2'b01 leave it unchanged; the change applies before the software-interrupt decision of the same step.
- R7: Modifier bit 2 (software interrupt) = 1 with the enable flag (after R6) set sends `pc_o` to 0, overriding bit 5 and suppressing the pop; a requested push still occurs.
- R8: Modifier bit 2 = 1 with the enable flag (after R6) clear has no effect: bits 5 and 3 act as in R3 and R4.
- R9: A rising edge on `kbd_irq_req` latches a pending request. At the next step with the request pending and `ien_o` = 1, the presented instruction is not executed; instead `pc_o` becomes 0, the old `pc_o` is pushed as in R5, `irq_taken_o` pulses and the pending request is cleared.
- R10: While `ien_o` is 0 a pending keyboard request stays pending and is taken at the first step after the flag becomes 1.
- R11: A cycle with `step_valid` low keeps `pc_o`, `sp_o` and `ien_o` and raises no stack request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| step_valid | input | 1 | An instruction retires this cycle |
| is_cflow | input | 1 | Presented instruction is a control-flow instruction |
| pred_pass | input | 1 | Predicate of the presented instruction holds |
| cf_mods | input | 6 | Modifiers: [5] relative, [4] push, [3] pop, [2] software interrupt, [1:0] enable toggle |
| reg_operand | input | WORD_W | Register operand used as target |
| stack_rdata | input | WORD_W | Current top-of-stack word |
| kbd_irq_req | input | 1 | Keyboard interrupt request level |
| pc_o | output | WORD_W | Program counter |
| sp_o | output | WORD_W | Stack pointer |
| ien_o | output | 1 | Interrupt-enable flag |
| irq_taken_o | output | 1 | Keyboard interrupt entered on the last step |
| push_o | output | 1 | Stack write request |
| push_addr_o | output | WORD_W | Stack write address |
| push_data_o | output | WORD_W | Stack write data |
| pop_o | output | 1 | Stack pop performed |

## Verification
On every cycle the assertions check the stack-pointer arithmetic of pushes and pops, the enable toggles, that an idle cycle changes nothing, that sequential steps advance by two, that a software or keyboard interrupt lands on address 0 without a pop, and that a pending request survives while interrupts are off. Only the bench's scenarios show the combined outcome of the modifier bits on the target value, the ordering of the toggle against the software-interrupt decision, the wrap of the program counter past 0xFFFE, and the exact step at which a deferred keyboard request is finally taken after the enable flag rises.

// File: rtl/cflow_pkg.sv
`timescale 1ns/1ps
package cflow_pkg;
  localparam int MODS_W = 6;
  localparam int BIT_REL  = 5;
  localparam int BIT_PUSH = 4;
  localparam int BIT_POP  = 3;
  localparam int BIT_SWI  = 2;

  typedef enum logic [1:0] {
    TOG_NONE0 = 2'b00,
    TOG_NONE1 = 2'b01,
    TOG_OFF   = 2'b10,
    TOG_ON    = 2'b11
  } tog_e;

  typedef struct packed {
    logic rel;
    logic push;
    logic pop;
    logic swi;
    tog_e tog;
  } cf_mods_t;
endpackage

// File: rtl/cflow_irq_ctrl.sv
`timescale 1ns/1ps
module cflow_irq_ctrl
  import cflow_pkg::*;
(
  input  logic clk,
  input  logic rst,
  input  logic step,
  input  logic exec,
  input  tog_e tog,
  input  logic kbd_req,
  output logic ien_q,
  output logic ien_eff,
  output logic take_hw,
  output logic pending_q
);
  logic kbd_prev_q;
  logic rise;

  assign rise    = kbd_req & ~kbd_prev_q;
  assign take_hw = step & pending_q & ien_q;

  always_comb begin
    unique case (tog)
      TOG_OFF: ien_eff = 1'b0;
      TOG_ON:  ien_eff = 1'b1;
      default: ien_eff = ien_q;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ien_q      <= 1'b0;
      pending_q  <= 1'b0;
      kbd_prev_q <= 1'b0;
    end else begin
      kbd_prev_q <= kbd_req;
      pending_q  <= (pending_q & ~take_hw) | rise;
      if (step && exec && !take_hw)
        ien_q <= ien_eff;
    end
  end

  // R6: toggle codes
  p_tog_off_r6: assert property (@(posedge clk) disable iff (rst)
    (step && exec && !take_hw && tog == TOG_OFF) |=> !ien_q);
  p_tog_on_r6: assert property (@(posedge clk) disable iff (rst)
    (step && exec && !take_hw && tog == TOG_ON) |=> ien_q);
  // R10: a pending request survives while disabled
  p_pend_hold_r10: assert property (@(posedge clk) disable iff (rst)
    (pending_q && !ien_q) |=> pending_q);
  // R9: entry clears the request unless a new edge arrives
  p_take_clears_r9: assert property (@(posedge clk) disable iff (rst)
    (take_hw && !rise) |=> !pending_q);
endmodule

// File: rtl/cflow_next_pc.sv
`timescale 1ns/1ps
module cflow_next_pc
  import cflow_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int PC_STEP    = 2,
  parameter int INT_VECTOR = 0
) (
  input  logic              step,
  input  logic              exec,
  input  logic              take_hw,
  input  logic              ien_eff,
  input  cf_mods_t          mods,
  input  logic [WORD_W-1:0] pc,
  input  logic [WORD_W-1:0] reg_operand,
  input  logic [WORD_W-1:0] stack_rdata,
  output logic [WORD_W-1:0] pc_next,
  output logic              do_push,
  output logic              do_pop,
  output logic              sw_jump
);
  localparam logic [WORD_W-1:0] STEP_V = WORD_W'(PC_STEP);
  localparam logic [WORD_W-1:0] VEC_V  = WORD_W'(INT_VECTOR);

  logic [WORD_W-1:0] target;
  logic [WORD_W-1:0] jump_pc;

  assign sw_jump = step & exec & ~take_hw & mods.swi & ien_eff;
  assign target  = mods.pop ? stack_rdata : reg_operand;
  assign jump_pc = mods.rel ? (pc + target) : target;

  always_comb begin
    pc_next = pc;
    do_push = 1'b0;
    do_pop  = 1'b0;
    if (step) begin
      if (take_hw) begin
        pc_next = VEC_V;
        do_push = 1'b1;
      end else if (exec) begin
        do_push = mods.push;
        if (sw_jump) begin
          pc_next = VEC_V;
        end else begin
          pc_next = jump_pc;
          do_pop  = mods.pop;
        end
      end else begin
        pc_next = pc + STEP_V;
      end
    end
  end
endmodule

// File: rtl/cflow_stack_ptr.sv
`timescale 1ns/1ps
module cflow_stack_ptr #(
  parameter int WORD_W   = 16,
  parameter int SP_RESET = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              do_push,
  input  logic              do_pop,
  input  logic [WORD_W-1:0] push_val,
  output logic [WORD_W-1:0] sp_q,
  output logic              push_q,
  output logic [WORD_W-1:0] push_addr_q,
  output logic [WORD_W-1:0] push_data_q,
  output logic              pop_q
);
  localparam logic [WORD_W-1:0] ONE = WORD_W'(1);

  logic [WORD_W-1:0] after_pop;
  logic [WORD_W-1:0] after_push;

  assign after_pop  = do_pop  ? (sp_q + ONE)      : sp_q;
  assign after_push = do_push ? (after_pop - ONE) : after_pop;

  always_ff @(posedge clk) begin
    if (rst) begin
      sp_q        <= WORD_W'(SP_RESET);
      push_q      <= 1'b0;
      push_addr_q <= '0;
      push_data_q <= '0;
      pop_q       <= 1'b0;
    end else begin
      sp_q   <= after_push;
      push_q <= do_push;
      pop_q  <= do_pop;
      if (do_push) begin
        push_addr_q <= after_push;
        push_data_q <= push_val;
      end
    end
  end

  // R5: lone push moves the pointer down and writes at the new top
  p_push_dec_r5: assert property (@(posedge clk) disable iff (rst)
    (do_push && !do_pop) |=> (sp_q == $past(sp_q) - ONE) && (push_addr_q == sp_q));
  // R5: push with pop keeps the pointer and overwrites the top
  p_swap_keep_r5: assert property (@(posedge clk) disable iff (rst)
    (do_push && do_pop) |=> (sp_q == $past(sp_q)) && (push_addr_q == sp_q));
  // R4: lone pop moves the pointer up
  p_pop_inc_r4: assert property (@(posedge clk) disable iff (rst)
    (do_pop && !do_push) |=> sp_q == $past(sp_q) + ONE);
endmodule

// File: rtl/cflow_irq_unit.sv
`timescale 1ns/1ps
module cflow_irq_unit
  import cflow_pkg::*;
#(
  parameter int WORD_W     = 16,
  parameter int PC_STEP    = 2,
  parameter int SP_RESET   = 0,
  parameter int INT_VECTOR = 0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              step_valid,
  input  logic              is_cflow,
  input  logic              pred_pass,
  input  logic [5:0]        cf_mods,
  input  logic [WORD_W-1:0] reg_operand,
  input  logic [WORD_W-1:0] stack_rdata,
  input  logic              kbd_irq_req,
  output logic [WORD_W-1:0] pc_o,
  output logic [WORD_W-1:0] sp_o,
  output logic              ien_o,
  output logic              irq_taken_o,
  output logic              push_o,
  output logic [WORD_W-1:0] push_addr_o,
  output logic [WORD_W-1:0] push_data_o,
  output logic              pop_o
);
  localparam logic [WORD_W-1:0] VEC_V  = WORD_W'(INT_VECTOR);
  localparam logic [WORD_W-1:0] STEP_V = WORD_W'(PC_STEP);

  cf_mods_t          mods;
  logic              exec;
  logic              ien_eff;
  logic              take_hw;
  logic              pending;
  logic              do_push;
  logic              do_pop;
  logic              sw_jump;
  logic [WORD_W-1:0] pc_q;
  logic [WORD_W-1:0] pc_next;
  logic              taken_q;

  assign mods = cf_mods_t'(cf_mods);
  assign exec = is_cflow & pred_pass;

  cflow_irq_ctrl u_irq (
    .clk       (clk),
    .rst       (rst),
    .step      (step_valid),
    .exec      (exec),
    .tog       (mods.tog),
    .kbd_req   (kbd_irq_req),
    .ien_q     (ien_o),
    .ien_eff   (ien_eff),
    .take_hw   (take_hw),
    .pending_q (pending)
  );

  cflow_next_pc #(
    .WORD_W     (WORD_W),
    .PC_STEP    (PC_STEP),
    .INT_VECTOR (INT_VECTOR)
  ) u_npc (
    .step        (step_valid),
    .exec        (exec),
    .take_hw     (take_hw),
    .ien_eff     (ien_eff),
    .mods        (mods),
    .pc          (pc_q),
    .reg_operand (reg_operand),
    .stack_rdata (stack_rdata),
    .pc_next     (pc_next),
    .do_push     (do_push),
    .do_pop      (do_pop),
    .sw_jump     (sw_jump)
  );

  cflow_stack_ptr #(
    .WORD_W   (WORD_W),
    .SP_RESET (SP_RESET)
  ) u_sp (
    .clk         (clk),
    .rst         (rst),
    .do_push     (do_push),
    .do_pop      (do_pop),
    .push_val    (pc_q),
    .sp_q        (sp_o),
    .push_q      (push_o),
    .push_addr_q (push_addr_o),
    .push_data_q (push_data_o),
    .pop_q       (pop_o)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pc_q    <= '0;
      taken_q <= 1'b0;
    end else begin
      pc_q    <= pc_next;
      taken_q <= take_hw;
    end
  end

  assign pc_o        = pc_q;
  assign irq_taken_o = taken_q;

  // R11: idle cycles change nothing
  p_idle_hold_r11: assert property (@(posedge clk) disable iff (rst)
    !step_valid |=> $stable(pc_o) && $stable(sp_o) && $stable(ien_o) && !push_o && !pop_o);
  // R2: non-executed steps advance sequentially
  p_seq_advance_r2: assert property (@(posedge clk) disable iff (rst)
    (step_valid && !exec && !take_hw) |=> (pc_o == $past(pc_o) + STEP_V) && !push_o && !pop_o);
  // R9: keyboard entry lands on the vector with a push and no pop
  p_hw_vector_r9: assert property (@(posedge clk) disable iff (rst)
    irq_taken_o |-> (pc_o == VEC_V) && push_o && !pop_o);
  // R7: software interrupt jump suppresses the pop
  p_sw_no_pop_r7: assert property (@(posedge clk) disable iff (rst)
    sw_jump |=> (pc_o == VEC_V) && !pop_o);
  // R5: pushed word is the address of the instruction
  p_push_data_r5: assert property (@(posedge clk) disable iff (rst)
    push_o |-> push_data_o == $past(pc_o));
endmodule

// File: tb/cflow_irq_unit_tb_top.sv
`timescale 1ns/1ps
module cflow_irq_unit_tb_top;
  logic        clk = 1'b0;
  logic        rst;
  logic        step_valid = 1'b0;
  logic        is_cflow = 1'b0;
  logic        pred_pass = 1'b0;
  logic [5:0]  cf_mods = '0;
  logic [15:0] reg_operand = '0;
  logic [15:0] stack_rdata = '0;
  logic        kbd_irq_req = 1'b0;
  logic [15:0] pc_o, sp_o, push_addr_o, push_data_o;
  logic        ien_o, irq_taken_o, push_o, pop_o;

  int n_checks = 0;
  int n_fails  = 0;
  bit finished = 0;

  // model state
  logic [15:0] m_pc, m_sp;
  logic        m_ien, m_pend, m_kprev;

  always #2 clk = ~clk;

  cflow_irq_unit dut_i (
    .clk(clk), .rst(rst), .step_valid(step_valid), .is_cflow(is_cflow),
    .pred_pass(pred_pass), .cf_mods(cf_mods), .reg_operand(reg_operand),
    .stack_rdata(stack_rdata), .kbd_irq_req(kbd_irq_req), .pc_o(pc_o),
    .sp_o(sp_o), .ien_o(ien_o), .irq_taken_o(irq_taken_o), .push_o(push_o),
    .push_addr_o(push_addr_o), .push_data_o(push_data_o), .pop_o(pop_o)
  );

  task automatic check(input string tag, input string what,
                       input logic [15:0] act, input logic [15:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  function automatic logic ien_after(input logic cur, input logic [1:0] t);
    if (t == 2'b10) return 1'b0;
    if (t == 2'b11) return 1'b1;
    return cur;
  endfunction

  // One clock: drive, predict, wait for the edge, compare.
  task automatic do_step(input string force_tag, input logic v, input logic cf,
                         input logic ps, input logic [5:0] md,
                         input logic [15:0] ro, input logic [15:0] rd,
                         input logic kb);
    logic e_push, e_pop, e_taken, rise, take, ie, ij;
    logic [15:0] e_pdata, e_paddr, tgt;
    string tag;
    step_valid = v; is_cflow = cf; pred_pass = ps; cf_mods = md;
    reg_operand = ro; stack_rdata = rd; kbd_irq_req = kb;
    e_push = 0; e_pop = 0; e_taken = 0; e_pdata = 0; e_paddr = 0;
    rise = kb & ~m_kprev;
    take = v & m_pend & m_ien;
    if (!v) tag = "R11";
    else if (take) begin
      tag = "R9";
      e_push = 1; e_pdata = m_pc; m_sp = m_sp - 16'd1; e_paddr = m_sp;
      m_pc = 16'h0000; e_taken = 1;
    end else if (cf && ps) begin
      ie = ien_after(m_ien, md[1:0]);
      ij = md[2] & ie;
      tgt = md[3] ? rd : ro;
      e_push = md[4];
      e_pop  = md[3] & ~ij;
      e_pdata = m_pc;
      if (e_pop) m_sp = m_sp + 16'd1;
      if (e_push) begin m_sp = m_sp - 16'd1; e_paddr = m_sp; end
      m_ien = ie;
      if (ij) begin tag = "R7"; m_pc = 16'h0000; end
      else begin
        tag = md[3] ? "R4" : (md[4] ? "R5" : "R3");
        m_pc = md[5] ? m_pc + tgt : tgt;
      end
    end else begin
      tag = "R2";
      m_pc = m_pc + 16'd2;
    end
    m_pend = (m_pend & ~take) | rise;
    m_kprev = kb;
    if (force_tag != "") tag = force_tag;
    @(posedge clk); #1;
    check(tag, "pc", pc_o, m_pc);
    check(tag, "sp", sp_o, m_sp);
    check(tag, "ien", 16'(ien_o), 16'(m_ien));
    check(tag, "push", 16'(push_o), 16'(e_push));
    check(tag, "pop", 16'(pop_o), 16'(e_pop));
    check(tag, "irq_taken", 16'(irq_taken_o), 16'(e_taken));
    if (e_push) begin
      check(tag, "push_data", push_data_o, e_pdata);
      check(tag, "push_addr", push_addr_o, e_paddr);
    end
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  endtask

  initial begin
    #400000;
    n_fails++;
    $display("FAIL watchdog: actual running expected done");
    finish_run();
  end

  initial begin
    void'($urandom(32'd20240611));
    rst = 1'b1;
    repeat (3) @(posedge clk);
    #1 rst = 1'b0;
    m_pc = 0; m_sp = 0; m_ien = 0; m_pend = 0; m_kprev = 0;
    // R1 reset state
    check("R1", "pc", pc_o, 16'h0);
    check("R1", "sp", sp_o, 16'h0);
    check("R1", "ien", 16'(ien_o), 16'h0);
    check("R1", "push", 16'(push_o), 16'h0);
    check("R1", "pop", 16'(pop_o), 16'h0);
    check("R1", "irq_taken", 16'(irq_taken_o), 16'h0);

    // R2 sequential advance and wrap at 0xFFFE
    do_step("R2", 1, 0, 1, 6'b000000, 16'h1234, 16'h0, 0);
    do_step("R3", 1, 1, 1, 6'b000000, 16'hFFFE, 16'h0, 0);
    do_step("R2", 1, 0, 0, 6'b000000, 16'h0, 16'h0, 0);
    // R2 predicate fail ignores modifiers
    do_step("R2", 1, 1, 0, 6'b111111, 16'h5555, 16'h7777, 0);
    // R3 relative wrap
    do_step("R3", 1, 1, 1, 6'b000000, 16'hFFFE, 16'h0, 0);
    do_step("R3", 1, 1, 1, 6'b100000, 16'h0004, 16'h0, 0);
    // R5 push alone, R4 pop alone, R5 push+pop
    do_step("R5", 1, 1, 1, 6'b010000, 16'h0100, 16'h0, 0);
    do_step("R4", 1, 1, 1, 6'b001000, 16'hAAAA, 16'h0102, 0);
    do_step("R5", 1, 1, 1, 6'b011000, 16'h0, 16'h0300, 0);
    // R11 idle
    do_step("R11", 0, 1, 1, 6'b011111, 16'h9999, 16'h8888, 0);
    // R6 toggles: 01 no change, 11 on, 00 no change, 10 off
    do_step("R6", 1, 1, 1, 6'b000001, 16'h0010, 16'h0, 0);
    do_step("R6", 1, 1, 1, 6'b000011, 16'h0020, 16'h0, 0);
    do_step("R6", 1, 1, 1, 6'b000000, 16'h0030, 16'h0, 0);
    // R8: toggle off then software interrupt in same step -> normal pop
    do_step("R8", 1, 1, 1, 6'b001110, 16'h0, 16'h0444, 0);
    // R7: toggle on then software interrupt with push and pop -> vector, push, no pop
    do_step("R7", 1, 1, 1, 6'b111111, 16'h0666, 16'h0555, 0);
    // R10: disable, raise keyboard, wait, then enable
    do_step("R6", 1, 1, 1, 6'b000010, 16'h0040, 16'h0, 0);
    do_step("R10", 1, 0, 1, 6'b0, 16'h0, 16'h0, 1);
    do_step("R10", 1, 0, 1, 6'b0, 16'h0, 16'h0, 1);
    do_step("R10", 0, 0, 1, 6'b0, 16'h0, 16'h0, 0);
    do_step("R10", 1, 1, 1, 6'b000011, 16'h0200, 16'h0, 0);
    do_step("R9", 1, 1, 1, 6'b100000, 16'h0008, 16'h0, 0);
    do_step("R2", 1, 0, 1, 6'b0, 16'h0, 16'h0, 0);

    // random mix
    for (int i = 0; i < 3000; i++) begin
      logic [5:0] md;
      logic v, cf, ps, kb;
      v  = ($urandom % 8) != 0;
      cf = ($urandom % 3) != 0;
      ps = ($urandom % 5) != 0;
      md = 6'($urandom);
      if (($urandom % 4) != 0) md[2] = 1'b0;
      kb = ($urandom % 6) == 0;
      do_step("", v, cf, ps, md, 16'($urandom), 16'($urandom), kb);
    end
    finish_run();
  end
endmodule